// File: doc/BRIEF.md
# Floating Status Exception Accumulator

This block keeps the status word of a floating-point unit current after every arithmetic result. The datapath offers one result summary per transfer: its sign, a 3-bit class code and the eight exception flags the operation raised. On acceptance the block rewrites the condition-code nibble from the sign and class. It replaces the exception byte with the new flags and ORs a sticky accrued field derived from them. It also compares the exception byte against the enable byte of the control word and raises a one-cycle trap request when any enabled exception is present.

Result summaries arrive on a valid/ready stream. A transfer happens on a rising clock edge where `upd_valid` and `upd_ready` are both high. `upd_ready` is low in any cycle where a direct status write (`wr_en`) is presented, because the write has priority. The producer must then hold its summary until a cycle without a write. The write path loads the whole status word and is the only way accrued bits are cleared. The control word is a plain level input sampled on the accepting edge.

Status word fields: condition codes at bits 27 (negative), 26 (zero), 25 (infinity) and 24 (not-a-number). The exception byte occupies bits 15..8: 15 unordered-branch, 14 signalling NaN, 13 operand error, 12 overflow, 11 underflow, 10 divide-by-zero, 9 inexact result, 8 inexact input. The accrued field occupies bits 7..3: 7 invalid, 6 overflow, 5 underflow, 4 divide-by-zero, 3 inexact. The control enable byte is `ctl_word[15:8]`, aligned bit for bit with the exception byte. `upd_exc[7:0]` maps onto status bits 15..8 in the same order.

Top module: `fsa_status_acc`

## Requirements
- R1: After reset `status_o` is zero and `trap_o` is low.
- R2: On an accepted update, bits 27..24 are first cleared and bit 27 is set equal to `upd_sign` for every class. Status bits outside 27..24 and 15..3 keep their previous value.
- R3: Class codes: 0 ordinary number sets none of bits 26..24, 1 zero sets bit 26, 2 infinity sets bit 25, 3 quiet NaN sets bit 24, 4 signalling NaN sets bit 24. Codes 5 to 7 are treated as ordinary numbers.
- R4: On an accepted update, bits 15..8 become `upd_exc`, with bit 14 additionally forced to 1 when the class is 4.
- R5: Accrued invalid (bit 7) is set when any of new bits 15, 14 or 13 is set.
- R6: Accrued overflow (bit 6) is set when new bit 12 is set. Accrued divide-by-zero (bit 4) is set when new bit 10 is set.
- R7: Accrued underflow (bit 5) is set only when new bits 11 and 9 are both set.
- R8: Accrued inexact (bit 3) is set when any of new bits 9, 8 or 12 is set.
- R9: Accrued bits are sticky: an update ORs into bits 7..3 and never clears them.
- R10: When `wr_en` is high, the next status equals `wr_data`, `upd_ready` is low in that cycle, and a presented update is not taken.
- R11: `trap_o` is high in the cycle after an accepted update exactly when (new bits 15..8) AND `ctl_word[15:8]` is nonzero. Otherwise it is low, so each accepted update yields at most one pulse.
- R12: When no update is accepted and no write is made, the status holds and `trap_o` is low, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Result summary offered |
| upd_ready | output | 1 | Summary can be taken this cycle |
| upd_sign | input | 1 | Result sign |
| upd_class | input | 3 | Result class code |
| upd_exc | input | 8 | Exception flags raised by the operation |
| ctl_word | input | 32 | Control word; bits 15..8 enable traps |
| wr_en | input | 1 | Direct status write |
| wr_data | input | 32 | Value for a direct status write |
| status_o | output | 32 | Current status word |
| trap_o | output | 1 | One-cycle trap request |

## Verification
The hardest situation to reach is a collision between a direct write and an offered update while accrued bits are already set. In that case the write must win, the offered summary must stay pending, and the accrued field must drop only because of the write. The stimulus first sets accrued bits with updates. It then presents write and update together and keeps the update valid into the following cycle, so the late acceptance and its trap are observed. Underflow without inexact, and inexact reached only through overflow, are driven as directed flag patterns. Long random runs with sparse writes then exercise stickiness.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  localparam int STAT_W = 32;
  localparam int EXC_W  = 8;
  localparam int CLS_W  = 3;
  localparam int ACC_W  = 5;

  localparam int CC_NEG = 27;
  localparam int CC_ZER = 26;
  localparam int CC_INF = 25;
  localparam int CC_NAN = 24;
  localparam int CC_LO  = CC_NAN;
  localparam int CC_HI  = CC_NEG;

  localparam int EXC_LO = 8;
  localparam int EXC_HI = EXC_LO + EXC_W - 1;
  localparam int ACC_LO = 3;
  localparam int ACC_HI = ACC_LO + ACC_W - 1;

  // positions inside the exception byte
  localparam int X_UNORD = 7;
  localparam int X_SNAN  = 6;
  localparam int X_OPERR = 5;
  localparam int X_OVFL  = 4;
  localparam int X_UNFL  = 3;
  localparam int X_DZ    = 2;
  localparam int X_INEXR = 1;
  localparam int X_INEXI = 0;

  // positions inside the accrued field
  localparam int A_INV  = 4;
  localparam int A_OVFL = 3;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 1;
  localparam int A_INEX = 0;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 3'd0,
    CLS_ZERO = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } res_class_e;

  typedef struct packed {
    logic neg;
    logic zer;
    logic inf;
    logic nan;
  } cc_t;
endpackage

// File: rtl/fsa_cc_gen.sv
module fsa_cc_gen
  import fsa_pkg::*;
(
  input  logic             sign_i,
  input  logic [CLS_W-1:0] class_i,
  input  logic [EXC_W-1:0] exc_i,
  output cc_t              cc_o,
  output logic [EXC_W-1:0] exc_o
);
  logic is_snan;

  always_comb begin
    cc_o     = '0;
    cc_o.neg = sign_i;
    is_snan  = 1'b0;
    case (class_i)
      CLS_ZERO: cc_o.zer = 1'b1;
      CLS_INF:  cc_o.inf = 1'b1;
      CLS_QNAN: cc_o.nan = 1'b1;
      CLS_SNAN: begin
        cc_o.nan = 1'b1;
        is_snan  = 1'b1;
      end
      default:  ;
    endcase
    exc_o = exc_i;
    exc_o[X_SNAN] = exc_i[X_SNAN] | is_snan;
  end

  // class flags never overlap (R3)
  always_comb begin
    p_cc_onehot_r3: assert ($onehot0({cc_o.zer, cc_o.inf, cc_o.nan}))
      else $error("class flags overlap");
  end
endmodule

// File: rtl/fsa_accrue.sv
module fsa_accrue
  import fsa_pkg::*;
(
  input  logic [EXC_W-1:0] exc_i,
  input  logic [ACC_W-1:0] acc_old_i,
  output logic [ACC_W-1:0] acc_new_o
);
  logic [ACC_W-1:0] raise;

  always_comb begin
    raise         = '0;
    raise[A_INV]  = exc_i[X_UNORD] | exc_i[X_SNAN] | exc_i[X_OPERR];
    raise[A_OVFL] = exc_i[X_OVFL];
    raise[A_UNFL] = exc_i[X_UNFL] & exc_i[X_INEXR];
    raise[A_DZ]   = exc_i[X_DZ];
    raise[A_INEX] = exc_i[X_INEXR] | exc_i[X_INEXI] | exc_i[X_OVFL];
  end

  genvar g;
  generate
    for (g = 0; g < ACC_W; g++) begin : g_sticky
      assign acc_new_o[g] = acc_old_i[g] | raise[g];
    end
  endgenerate

  // underflow accrues only with inexact result (R7)
  always_comb begin
    p_unfl_needs_inex_r7: assert (!(acc_new_o[A_UNFL] && !acc_old_i[A_UNFL])
                                  || (exc_i[X_UNFL] && exc_i[X_INEXR]))
      else $error("underflow accrued without inexact");
  end
endmodule

// File: rtl/fsa_trap_cmp.sv
module fsa_trap_cmp
  import fsa_pkg::*;
(
  input  logic [EXC_W-1:0] exc_i,
  input  logic [EXC_W-1:0] en_i,
  output logic             hit_o
);
  assign hit_o = |(exc_i & en_i);
endmodule

// File: rtl/fsa_status_acc.sv
module fsa_status_acc
  import fsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_sign,
  input  logic [CLS_W-1:0]  upd_class,
  input  logic [EXC_W-1:0]  upd_exc,
  input  logic [STAT_W-1:0] ctl_word,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o
);
  logic [STAT_W-1:0] status_q, status_upd;
  logic              trap_q, take, hit;
  cc_t               cc_new;
  logic [EXC_W-1:0]  exc_new;
  logic [ACC_W-1:0]  acc_new;

  assign upd_ready = ~wr_en;
  assign take      = upd_valid & upd_ready;

  fsa_cc_gen u_cc (
    .sign_i (upd_sign),
    .class_i(upd_class),
    .exc_i  (upd_exc),
    .cc_o   (cc_new),
    .exc_o  (exc_new)
  );

  fsa_accrue u_acc (
    .exc_i    (exc_new),
    .acc_old_i(status_q[ACC_HI:ACC_LO]),
    .acc_new_o(acc_new)
  );

  fsa_trap_cmp u_trap (
    .exc_i(exc_new),
    .en_i (ctl_word[EXC_HI:EXC_LO]),
    .hit_o(hit)
  );

  always_comb begin
    status_upd                 = status_q;
    status_upd[CC_HI:CC_LO]    = cc_new;
    status_upd[EXC_HI:EXC_LO]  = exc_new;
    status_upd[ACC_HI:ACC_LO]  = acc_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else if (wr_en) begin
      status_q <= wr_data;
      trap_q   <= 1'b0;
    end else if (take) begin
      status_q <= status_upd;
      trap_q   <= hit;
    end else begin
      trap_q   <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign trap_o   = trap_q;

  p_write_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status_o == $past(wr_data))
    else $error("write not loaded");

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_valid) |=> ($stable(status_o) && !trap_o))
    else $error("status moved while idle");

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status_o[ACC_HI:ACC_LO] & $past(status_o[ACC_HI:ACC_LO]))
                == $past(status_o[ACC_HI:ACC_LO])))
    else $error("accrued bit lost");

  p_trap_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && !wr_en) |=> !trap_o)
    else $error("trap without accepted update");

  p_neg_follows_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !wr_en) |=> status_o[CC_NEG] == $past(upd_sign))
    else $error("negative flag wrong");
endmodule

// File: tb/fsa_status_acc_tb.sv
module fsa_status_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic        upd_sign = 1'b0;
  logic [2:0]  upd_class = '0;
  logic [7:0]  upd_exc = '0;
  logic [31:0] ctl_word = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_o;
  logic        trap_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_st = '0;
  logic        exp_tr = 1'b0;

  always #10 clk = ~clk;

  fsa_status_acc u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_sign(upd_sign), .upd_class(upd_class), .upd_exc(upd_exc),
    .ctl_word(ctl_word), .wr_en(wr_en), .wr_data(wr_data),
    .status_o(status_o), .trap_o(trap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // behavioural model of one clock
  task automatic model();
    logic [7:0] ex;
    logic [4:0] acc;
    if (wr_en) begin
      exp_st = wr_data;
      exp_tr = 1'b0;
    end else if (upd_valid) begin
      ex = upd_exc;
      if (upd_class == 3'd4) ex[6] = 1'b1;
      acc = exp_st[7:3];
      if (ex[7] || ex[6] || ex[5]) acc[4] = 1'b1;
      if (ex[4]) acc[3] = 1'b1;
      if (ex[3] && ex[1]) acc[2] = 1'b1;
      if (ex[2]) acc[1] = 1'b1;
      if (ex[1] || ex[0] || ex[4]) acc[0] = 1'b1;
      exp_st[27] = upd_sign;
      exp_st[26] = (upd_class == 3'd1);
      exp_st[25] = (upd_class == 3'd2);
      exp_st[24] = (upd_class == 3'd3) || (upd_class == 3'd4);
      exp_st[15:8] = ex;
      exp_st[7:3] = acc;
      exp_tr = (ex & ctl_word[15:8]) != 8'h00;
    end else begin
      exp_tr = 1'b0;
    end
  endtask

  // inputs are set at a falling edge; one clock later outputs are compared
  task automatic step(input string req, input bit v, input bit s, input logic [2:0] c,
                      input logic [7:0] e, input logic [7:0] en,
                      input bit w, input logic [31:0] wd);
    upd_valid = v; upd_sign = s; upd_class = c; upd_exc = e;
    ctl_word = {16'h0, en, 8'h0}; wr_en = w; wr_data = wd;
    #1;
    chk({req, " ready"}, {31'b0, upd_ready}, {31'b0, !w});
    model();
    @(negedge clk);
    chk({req, " status"}, status_o, exp_st);
    chk({req, " trap"}, {31'b0, trap_o}, {31'b0, exp_tr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 32'h0);
    chk("R1 trap", {31'b0, trap_o}, 32'h0);
    rst_n = 1'b1;
    exp_st = '0; exp_tr = 1'b0;
    // R3 classes with R2 sign
    step("R3 number", 1, 0, 3'd0, 8'h00, 8'h00, 0, 0);
    step("R3 zero neg R2", 1, 1, 3'd1, 8'h00, 8'h00, 0, 0);
    step("R3 inf", 1, 0, 3'd2, 8'h00, 8'h00, 0, 0);
    step("R3 qnan neg R2", 1, 1, 3'd3, 8'h00, 8'h00, 0, 0);
    step("R3 reserved class", 1, 0, 3'd6, 8'h00, 8'h00, 0, 0);
    step("R4 snan", 1, 0, 3'd4, 8'h00, 8'h00, 0, 0);
    step("R10 clear", 0, 0, 0, 0, 0, 1, 32'h0);
    // accrual rules
    step("R7 unfl alone", 1, 0, 3'd0, 8'h08, 8'h00, 0, 0);
    step("R7 unfl+inex", 1, 0, 3'd0, 8'h0A, 8'h00, 0, 0);
    step("R10 clear2", 0, 0, 0, 0, 0, 1, 32'h0);
    step("R8 ovfl gives inex R6", 1, 0, 3'd0, 8'h10, 8'h00, 0, 0);
    step("R10 clear3", 0, 0, 0, 0, 0, 1, 32'h0);
    step("R5 operr", 1, 0, 3'd0, 8'h20, 8'h00, 0, 0);
    step("R6 dz", 1, 0, 3'd0, 8'h04, 8'h00, 0, 0);
    step("R9 sticky", 1, 0, 3'd0, 8'h00, 8'h00, 0, 0);
    step("R5 unord", 1, 0, 3'd0, 8'h80, 8'h00, 0, 0);
    step("R8 inexact input", 1, 0, 3'd0, 8'h01, 8'h00, 0, 0);
    // trap
    step("R11 enabled", 1, 0, 3'd0, 8'h04, 8'h04, 0, 0);
    step("R11 pulse ends R12", 0, 0, 0, 8'h04, 8'h04, 0, 0);
    step("R11 disabled", 1, 0, 3'd0, 8'h04, 8'h10, 0, 0);
    step("R11 snan trap", 1, 0, 3'd4, 8'h00, 8'h40, 0, 0);
    // collision: write wins, update held and taken next cycle
    step("R10 collide", 1, 1, 3'd2, 8'h10, 8'h10, 1, 32'h00A0_0005);
    step("R10 late take R11", 1, 1, 3'd2, 8'h10, 8'h10, 0, 0);
    step("R12 idle", 0, 1, 3'd1, 8'hFF, 8'hFF, 0, 0);
    step("R2 other bits kept", 1, 0, 3'd0, 8'h00, 8'h00, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2/R9/R11 random", r[0] | r[1], r[2], r[5:3], r[13:6], r[21:14],
           (r[26:22] == 5'd0), $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule